// File: doc/BRIEF.md
# Configurable Vector Reduction Tree

This block takes a 64-lane vector from an element-wise map stage and collapses it under program control. The lanes are 16 bits each and are read as unsigned. The operator is chosen per input vector. Summation gives the totals used for sum-of-absolute-difference searches. A logical all-true test gives the flags used for extrema detection. The third choice is no reduction, which hands the vector on unchanged for element-wise work such as difference-of-Gaussian images or sub-pixel averaging.

A group-size setting cuts the lanes into independent runs of consecutive lanes, starting at lane 0. Each run yields its own result, so several stencils can be reduced in one pass: sixteen-lane tiles, or 1D windows of 3, 6, 9, 13 or 15 taps. Lanes past the last whole run are dropped.

The datapath is pipelined. Results, a valid flag and the number of groups come out a fixed number of cycles after each accepted input.

Top module: `vector_reduce_tree`

## Requirements
- R1: An input presented with `in_valid` high at a rising edge produces `out_valid` high for exactly one cycle, visible after the fourth rising edge that follows the capture edge (five registers in total). `out_valid` is low in every cycle that has no such input.
- R2: With `in_mode` = 1 (sum), result slot k, at bits [22k+21:22k] of `out_result`, holds the full-precision sum of lanes k*g to k*g+g-1, where g is the group size. Lane i sits at bits [16i+15:16i] of `in_lanes`. A single group of 64 lanes all at 0xFFFF gives 4194240 with no wrap.
- R3: With `in_mode` = 2 (all-true), slot k is 1 when every lane of group k is nonzero and 0 when any lane of the group is zero.
- R4: With `in_mode` = 0 or 3 (pass), slot k equals lane k zero-extended to 22 bits, and `out_groups` is 64, whatever `in_group` holds.
- R5: `out_groups` equals floor(64/g), and every slot at or above that index is 0. Lanes beyond the last whole group have no effect on any slot.
- R6: An `in_group` of 0 acts as a group size of 1, and any value above 64 acts as 64.
- R7: Mode and group size are taken together with each valid input. Back-to-back inputs with different settings each produce results under their own settings, and a change never alters a result already in the pipeline.
- R8: While `rst_n` is low at a rising edge, `out_valid`, `out_groups` and `out_result` are 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input vector is valid this cycle |
| in_lanes | input | 1024 | 64 lanes of 16 bits, lane i at [16i+15:16i] |
| in_mode | input | 2 | 0 pass, 1 sum, 2 all-true, 3 pass |
| in_group | input | 7 | Group size in lanes, clamped to 1..64 |
| out_valid | output | 1 | Results are valid this cycle |
| out_result | output | 1408 | 64 slots of 22 bits, slot k at [22k+21:22k] |
| out_groups | output | 7 | Number of meaningful slots |

## Verification
Every result is due after the fourth rising edge after its capture edge. The driver stamps each expected item with that due cycle when it pushes the item into the scoreboard queue. The monitor samples on falling edges and compares only when the item at the head of the queue is due in that cycle. A missing `out_valid` at that cycle, or an `out_valid` in any other cycle, is reported against R1. Back-to-back inputs with changing settings check that each result keeps the settings it entered with, one per cycle, in order.

// File: rtl/redtree_pkg.sv
// Package: shared mode encoding for the vector reduction tree.
// Assumes a 2-bit mode field; code 3 behaves like code 0.
package redtree_pkg;
    typedef enum logic [1:0] {
        MODE_PASS     = 2'd0,
        MODE_SUM      = 2'd1,
        MODE_ALL      = 2'd2,
        MODE_PASS_ALT = 2'd3
    } rmode_e;
endpackage

// File: rtl/redtree_ingress.sv
// Module: redtree_ingress
// Captures the lane vector and settings into the first pipeline register.
// Pass mode is folded into sum mode with a group size of 1. In all-true mode
// each lane is recoded as a 1-bit "lane is zero" flag, so that the later
// prefix network counts zero lanes. Assumes unsigned lanes.
module redtree_ingress
    import redtree_pkg::*;
#(
    parameter int LANES = 64,
    parameter int IN_W  = 16,
    parameter int SUM_W = 22,
    parameter int GW    = 7
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [LANES*IN_W-1:0]  in_lanes,
    input  logic [1:0]             in_mode,
    input  logic [GW-1:0]          in_group,
    output logic [SUM_W-1:0]       lane_q [LANES],
    output logic                   vld_q,
    output logic                   all_q,
    output logic [GW-1:0]          grp_q
);
    logic          is_all;
    logic          is_pass;
    logic [GW-1:0] grp_eff;

    // Decode the mode and clamp the group size to 1..LANES.
    always_comb begin
        is_all  = (in_mode == MODE_ALL);
        is_pass = (in_mode != MODE_SUM) && (in_mode != MODE_ALL);
        if (is_pass || in_group == '0)
            grp_eff = GW'(1);
        else if (in_group > GW'(LANES))
            grp_eff = GW'(LANES);
        else
            grp_eff = in_group;
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [IN_W-1:0] raw;
        assign raw = in_lanes[i*IN_W +: IN_W];
        // Register the lane value, or its zero flag in all-true mode.
        always_ff @(posedge clk) begin
            lane_q[i] <= is_all ? SUM_W'(raw == '0) : SUM_W'(raw);
        end
    end

    // Register the sideband that travels with the vector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
            all_q <= 1'b0;
            grp_q <= '0;
        end else begin
            vld_q <= in_valid;
            all_q <= is_all;
            grp_q <= grp_eff;
        end
    end
endmodule

// File: rtl/redtree_scan.sv
// Module: redtree_scan
// Inclusive prefix-sum network over LANES values, with log2(LANES) levels.
// Level j adds the value 2^j lanes below. A register follows every second
// level and the last level. The sideband is delayed by the same number of
// registers. Assumes LANES is a power of two and SUM_W holds the full sum.
module redtree_scan #(
    parameter int LANES = 64,
    parameter int SUM_W = 22,
    parameter int SBW   = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SUM_W-1:0] d_in  [LANES],
    input  logic [SBW-1:0]   sb_in,
    output logic [SUM_W-1:0] d_out [LANES],
    output logic [SBW-1:0]   sb_out
);
    localparam int LVLS = $clog2(LANES);

    for (genvar j = 0; j < LVLS; j++) begin : g_lvl
        localparam int DIST = 1 << j;
        localparam bit REG  = (j % 2 == 1) || (j == LVLS - 1);
        logic [SUM_W-1:0] src [LANES];
        logic [SUM_W-1:0] nx  [LANES];
        logic [SUM_W-1:0] q   [LANES];
        logic [SBW-1:0]   src_sb;
        logic [SBW-1:0]   q_sb;

        if (j == 0) begin : g_first
            assign src    = d_in;
            assign src_sb = sb_in;
        end else begin : g_next
            assign src    = g_lvl[j-1].q;
            assign src_sb = g_lvl[j-1].q_sb;
        end

        for (genvar i = 0; i < LANES; i++) begin : g_add
            if (i >= DIST) begin : g_sum
                assign nx[i] = src[i] + src[i-DIST];
            end else begin : g_keep
                assign nx[i] = src[i];
            end
        end

        if (REG) begin : g_reg
            // Pipeline register for the partial prefix sums.
            always_ff @(posedge clk) begin
                for (int i = 0; i < LANES; i++) q[i] <= nx[i];
            end
            // Pipeline register for the sideband, cleared on reset.
            always_ff @(posedge clk) begin
                if (!rst_n) q_sb <= '0;
                else        q_sb <= src_sb;
            end
        end else begin : g_wire
            assign q    = nx;
            assign q_sb = src_sb;
        end
    end

    assign d_out  = g_lvl[LVLS-1].q;
    assign sb_out = g_lvl[LVLS-1].q_sb;
endmodule

// File: rtl/redtree_pick.sv
// Module: redtree_pick
// Forms per-group results from the prefix sums. Group k spans lanes
// [k*g, k*g+g-1]. Its total is the prefix at its last lane minus the prefix
// just below its first lane. In all-true mode that difference is the count of
// zero lanes, so the result is 1 when the count is zero. Slots without a whole
// group are forced to 0. Registers the outputs.
module redtree_pick #(
    parameter int LANES = 64,
    parameter int SUM_W = 22,
    parameter int GW    = 7
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [SUM_W-1:0]       pre [LANES],
    input  logic                   vld,
    input  logic                   all_mode,
    input  logic [GW-1:0]          grp,
    output logic [LANES*SUM_W-1:0] res,
    output logic                   res_valid,
    output logic [GW-1:0]          res_groups
);
    localparam int LW = $clog2(LANES);

    logic [LANES-1:0]       slot_ok;
    logic [LANES*SUM_W-1:0] res_nx;

    for (genvar k = 0; k < LANES; k++) begin : g_slot
        int               hi;
        int               lo;
        logic             ok;
        logic [SUM_W-1:0] up;
        logic [SUM_W-1:0] dn;
        logic [SUM_W-1:0] diff;
        logic [SUM_W-1:0] val;
        // Locate the group bounds and subtract the two prefix values.
        always_comb begin
            hi   = (k + 1) * int'(grp);
            lo   = k * int'(grp);
            ok   = (hi <= LANES);
            up   = pre[LW'(hi - 1)];
            dn   = (k == 0) ? '0 : pre[LW'(lo - 1)];
            diff = up - dn;
            val  = all_mode ? SUM_W'(diff == '0) : diff;
        end
        assign slot_ok[k]                 = ok;
        assign res_nx[k*SUM_W +: SUM_W]   = ok ? val : '0;
    end

    // Output register: results, valid flag and group count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res        <= '0;
            res_valid  <= 1'b0;
            res_groups <= '0;
        end else begin
            res        <= res_nx;
            res_valid  <= vld;
            res_groups <= GW'($countones(slot_ok));
        end
    end
endmodule

// File: rtl/vector_reduce_tree.sv
// Module: vector_reduce_tree (top)
// Runtime-configurable reduction of a lane vector: sum, all-true or pass,
// over groups of consecutive lanes. Latency is a fixed five registers:
// ingress, three prefix-network stages and the output stage.
// Assumes LANES is a power of two.
module vector_reduce_tree #(
    parameter int LANES = 64,
    parameter int IN_W  = 16,
    parameter int SUM_W = IN_W + $clog2(LANES),
    parameter int GW    = $clog2(LANES) + 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [LANES*IN_W-1:0]  in_lanes,
    input  logic [1:0]             in_mode,
    input  logic [GW-1:0]          in_group,
    output logic                   out_valid,
    output logic [LANES*SUM_W-1:0] out_result,
    output logic [GW-1:0]          out_groups
);
    localparam int SBW = GW + 2;

    logic [SUM_W-1:0] lane_q [LANES];
    logic [SUM_W-1:0] pre    [LANES];
    logic             vld_q;
    logic             all_q;
    logic [GW-1:0]    grp_q;
    logic [SBW-1:0]   sb_in;
    logic [SBW-1:0]   sb_out;

    redtree_ingress #(.LANES(LANES), .IN_W(IN_W), .SUM_W(SUM_W), .GW(GW)) u_in (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_lanes (in_lanes),
        .in_mode  (in_mode),
        .in_group (in_group),
        .lane_q   (lane_q),
        .vld_q    (vld_q),
        .all_q    (all_q),
        .grp_q    (grp_q)
    );

    assign sb_in = {vld_q, all_q, grp_q};

    redtree_scan #(.LANES(LANES), .SUM_W(SUM_W), .SBW(SBW)) u_scan (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_in   (lane_q),
        .sb_in  (sb_in),
        .d_out  (pre),
        .sb_out (sb_out)
    );

    redtree_pick #(.LANES(LANES), .SUM_W(SUM_W), .GW(GW)) u_pick (
        .clk        (clk),
        .rst_n      (rst_n),
        .pre        (pre),
        .vld        (sb_out[SBW-1]),
        .all_mode   (sb_out[SBW-2]),
        .grp        (sb_out[GW-1:0]),
        .res        (out_result),
        .res_valid  (out_valid),
        .res_groups (out_groups)
    );
endmodule

// File: rtl/redtree_chk.sv
// Module: redtree_chk
// Property checker bound to vector_reduce_tree. Its window checks are
// guarded by a count of the cycles since reset.
module redtree_chk
    import redtree_pkg::*;
#(
    parameter int LANES = 64,
    parameter int SUM_W = 22,
    parameter int GW    = 7
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   in_valid,
    input logic [1:0]             in_mode,
    input logic                   out_valid,
    input logic [LANES*SUM_W-1:0] out_result,
    input logic [GW-1:0]          out_groups
);
    logic [3:0] since_rst;
    logic       tail_bad;
    logic       wide_bits;

    // Count the cycles since reset, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                  since_rst <= '0;
        else if (since_rst != 4'hF)  since_rst <= since_rst + 4'd1;
    end

    // Flag nonzero slots past the group count, and slots wider than one bit.
    always_comb begin
        tail_bad  = 1'b0;
        wide_bits = 1'b0;
        for (int k = 0; k < LANES; k++) begin
            if (k >= int'(out_groups) && out_result[k*SUM_W +: SUM_W] != '0) tail_bad = 1'b1;
            if (out_result[k*SUM_W+1 +: SUM_W-1] != '0) wide_bits = 1'b1;
        end
    end

    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_groups == '0)); // R8
    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 4'd5) |-> (out_valid == $past(in_valid, 5))); // R1
    AST_GROUP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_groups >= GW'(1) && out_groups <= GW'(LANES))); // R5
    AST_TAIL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !tail_bad); // R5
    AST_FLAG_BINARY: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 4'd5 && out_valid && $past(in_mode, 5) == MODE_ALL) |-> !wide_bits); // R3
    AST_PASS_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 4'd5 && out_valid && ($past(in_mode, 5) == MODE_PASS || $past(in_mode, 5) == MODE_PASS_ALT))
        |-> out_groups == GW'(LANES)); // R4
endmodule

bind vector_reduce_tree redtree_chk #(.LANES(LANES), .SUM_W(SUM_W), .GW(GW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_mode    (in_mode),
    .out_valid  (out_valid),
    .out_result (out_result),
    .out_groups (out_groups)
);

// File: tb/vector_reduce_tree_test.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes expected items stamped with their due
// cycle, and a monitor pops and compares them on falling edges.
module vector_reduce_tree_test;
    localparam int LANES = 64;
    localparam int IN_W  = 16;
    localparam int SUM_W = 22;
    localparam int GW    = 7;
    localparam int LAT   = 5;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   in_valid = 1'b0;
    logic [LANES*IN_W-1:0]  in_lanes = '0;
    logic [1:0]             in_mode = 2'd0;
    logic [GW-1:0]          in_group = '0;
    logic                   out_valid;
    logic [LANES*SUM_W-1:0] out_result;
    logic [GW-1:0]          out_groups;

    vector_reduce_tree uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_lanes(in_lanes),
        .in_mode(in_mode), .in_group(in_group), .out_valid(out_valid),
        .out_result(out_result), .out_groups(out_groups)
    );

    always #2.5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        logic [LANES*SUM_W-1:0] res;
        int                     groups;
        int                     due;
        string                  req;
    } exp_t;

    exp_t sb_q[$];
    int   total = 0;
    int   bad = 0;
    bit   finished = 1'b0;

    // Reference model written from the requirements, lane by lane.
    function automatic exp_t model(input logic [LANES*IN_W-1:0] ln, input logic [1:0] md,
                                   input int gin, input string req);
        exp_t e;
        int   g;
        bit   all_m;
        e.res = '0;
        e.req = req;
        all_m = (md == 2'd2);
        if (md == 2'd0 || md == 2'd3) g = 1;
        else if (gin == 0)            g = 1;
        else if (gin > LANES)         g = LANES;
        else                          g = gin;
        e.groups = LANES / g;
        for (int k = 0; k < e.groups; k++) begin
            int s = 0;
            bit nz = 1'b1;
            for (int j = 0; j < g; j++) begin
                int v = int'(ln[(k*g+j)*IN_W +: IN_W]);
                s += v;
                if (v == 0) nz = 1'b0;
            end
            e.res[k*SUM_W +: SUM_W] = all_m ? SUM_W'(nz) : SUM_W'(s);
        end
        return e;
    endfunction

    function automatic logic [LANES*IN_W-1:0] rnd_lanes(input int zero_pct);
        logic [LANES*IN_W-1:0] v;
        for (int i = 0; i < LANES; i++) begin
            if (int'($urandom_range(99)) < zero_pct) v[i*IN_W +: IN_W] = '0;
            else v[i*IN_W +: IN_W] = IN_W'($urandom_range(65535, 1));
        end
        return v;
    endfunction

    // Driver: present one input at a falling edge and push its expectation.
    task automatic send(input logic [LANES*IN_W-1:0] ln, input logic [1:0] md,
                        input int g, input string req);
        exp_t e;
        in_lanes = ln;
        in_mode  = md;
        in_group = GW'(g);
        in_valid = 1'b1;
        e = model(ln, md, g, req);
        e.due = cyc + LAT;
        sb_q.push_back(e);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        in_valid = 1'b0;
        in_lanes = rnd_lanes(0);
        in_mode  = 2'($urandom_range(3));
        in_group = GW'($urandom_range(127));
        repeat (n) @(negedge clk);
    endtask

    // Monitor: compare results at their due cycle; flag stray valids (R1).
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (sb_q.size() > 0 && sb_q[0].due == cyc) begin
                exp_t e;
                e = sb_q.pop_front();
                total++;
                if (!out_valid) begin
                    bad++;
                    $display("FAIL R1 (%s): out_valid actual=0 expected=1 at cycle %0d", e.req, cyc);
                end else if (int'(out_groups) != e.groups) begin
                    bad++;
                    $display("FAIL %s R5: out_groups actual=%0d expected=%0d", e.req, out_groups, e.groups);
                end else if (out_result != e.res) begin
                    int k0 = 0;
                    for (int k = LANES - 1; k >= 0; k--)
                        if (out_result[k*SUM_W +: SUM_W] != e.res[k*SUM_W +: SUM_W]) k0 = k;
                    bad++;
                    $display("FAIL %s: slot %0d actual=%0d expected=%0d", e.req, k0,
                             out_result[k0*SUM_W +: SUM_W], e.res[k0*SUM_W +: SUM_W]);
                end
            end else if (out_valid) begin
                total++;
                bad++;
                $display("FAIL R1: out_valid actual=1 expected=0 at cycle %0d", cyc);
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        logic [LANES*IN_W-1:0] v;
        repeat (3) @(negedge clk);
        total++;   // R8: reset state
        if (out_valid !== 1'b0 || out_groups !== '0 || out_result !== '0) begin
            bad++;
            $display("FAIL R8: reset outputs actual valid=%0b groups=%0d expected 0 0", out_valid, out_groups);
        end
        rst_n = 1'b1;
        idle(2);

        send(rnd_lanes(10), 2'd1, 16, "R2 sum g16");        idle(3);
        v = '1;
        send(v, 2'd1, 64, "R2 sum g64 all-ones");           idle(2);
        v = rnd_lanes(0); v[63*IN_W +: IN_W] = 16'hFFFF;
        send(v, 2'd1, 3, "R5 sum g3 leftover lane");        idle(2);
        send(rnd_lanes(5), 2'd1, 15, "R2 sum g15");         idle(1);
        send(rnd_lanes(5), 2'd1, 9, "R2 sum g9");           idle(2);
        send(rnd_lanes(8), 2'd2, 4, "R3 all g4");           idle(2);
        send(rnd_lanes(3), 2'd2, 13, "R3 all g13");         idle(2);
        v = rnd_lanes(0); for (int i = 60; i < 64; i++) v[i*IN_W +: IN_W] = '0;
        send(v, 2'd2, 5, "R5 all g5 zero leftovers");       idle(2);
        send(rnd_lanes(20), 2'd0, 7, "R4 pass code0");      idle(2);
        send(rnd_lanes(20), 2'd3, 32, "R4 pass code3");     idle(2);
        send(rnd_lanes(0), 2'd1, 0, "R6 group 0");          idle(2);
        send(rnd_lanes(0), 2'd1, 100, "R6 group 100");      idle(2);
        send(rnd_lanes(0), 2'd1, 6, "R7 b2b sum g6");
        send(rnd_lanes(15), 2'd2, 9, "R7 b2b all g9");
        send(rnd_lanes(0), 2'd0, 2, "R7 b2b pass");
        send(rnd_lanes(0), 2'd1, 64, "R7 b2b sum g64");
        idle(LAT + 3);

        if (sb_q.size() != 0) begin
            total++;
            bad++;
            $display("FAIL R1: pending results actual=%0d expected=0", sb_q.size());
        end
        finish_run();
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R1: watchdog expired actual=hang expected=done");
        finish_run();
    end
endmodule